// File: doc/BRIEF.md
# Quad DAC Command Register Bank

This block is the digital control core of a four-channel digital-to-analog converter. It receives complete 24-bit write words, each marked by a one-cycle valid strobe. The top byte holds a 4-bit command in bits 7:4 and a 4-bit channel address in bits 3:0. The remaining 16 bits are a data word, most significant bit first. Each channel has two registers in series. An input register is loaded by write commands. A DAC register holds the active code and is loaded from the input register by update commands. Each channel also has a power-down flag.

Any update of a powered-down channel powers that channel up again. It also starts a settling timer for the channel, and a per-channel settle flag stays high while the timer runs. The timer is short when at least one channel was still powered up at the moment of the update. It is long when all four channels were powered down. Both lengths are set in nanoseconds and converted to cycles from a clock-frequency parameter.

Reduced-resolution builds are supported. The code is taken from the top bits of the data word (left-justified), and the low bits are ignored.

Top module: `qdac_cmd_core`

## Requirements
- R1: While reset is high and on the cycle after it, every active code is zero, every power-down flag is 0 and every settle flag is 0.
- R2: Command 4'h0 loads the data word into the input register of the addressed channel. No active code and no flag changes. A word accepted at a rising edge shows its effect on the outputs right after that edge.
- R3: Command 4'h1 copies the addressed channel's input register into its DAC register and clears that channel's power-down flag.
- R4: Command 4'h2 loads the addressed input register, then updates all four DAC registers from their input registers (the addressed ones receive the new word) and clears all power-down flags.
- R5: Command 4'h3 loads the data word into both registers of the addressed channel and clears its power-down flag.
- R6: Command 4'h4 sets the power-down flag of the addressed channel(s). The data word is ignored, and neither register of any channel changes.
- R7: Address 4'h0, 4'h1, 4'h2 and 4'h3 select channel A, B, C and D. Address 4'hF selects all four channels. Channel A is the least significant slice of each output bus.
- R8: Command 4'hF, any command other than 4'h0 to 4'h4 and 4'hF, and any address other than 4'h0 to 4'h3 and 4'hF change no register and no flag.
- R9: An update of a powered-down channel, while fewer than four channels are powered down, raises that channel's settle flag for exactly WAKE_SHORT_NS worth of clock cycles (250 cycles at 50 MHz and 5000 ns).
- R10: An update of a powered-down channel, while all four channels are powered down, raises its settle flag for exactly WAKE_LONG_NS worth of cycles (500 cycles at 50 MHz and 10000 ns).
- R11: A settle flag is never high while its channel is powered down. Powering a channel down clears its settle flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write word present this cycle |
| wr_cmd_addr | input | 8 | Command in bits 7:4, channel address in bits 3:0 |
| wr_data | input | 16 | Data word, code left-justified |
| dac_code | output | NCH*CODE_W | Active code per channel, channel A in the lowest slice |
| pd_flag | output | NCH | Power-down state per channel |
| settle_flag | output | NCH | Wake-up settling in progress per channel |

## Verification
On every cycle, the assertions check the reset state, and that power-down, load-only, no-op and reserved words leave the active codes stable. They also check that a power-down to all channels sets every flag, that a load-and-update-all word clears every flag, and that a settle flag never rises on a channel that was not powered down just before. The bench's reference model and its scenarios are the only place several things are shown. These are the double-buffered path from input register to DAC register, including non-addressed channels updated from stale input registers. They are also the exact short and long settle lengths, which depend on how many channels were down, and the rejection of reserved codes as seen through a later update.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [3:0] {
    CMD_LOAD         = 4'h0,
    CMD_UPDATE       = 4'h1,
    CMD_LOAD_UPD_ALL = 4'h2,
    CMD_LOAD_UPD     = 4'h3,
    CMD_PWR_DN       = 4'h4,
    CMD_NOP          = 4'hF
  } qdac_cmd_e;

  localparam logic [3:0] ADDR_ALL = 4'hF;

  // Converts a duration in nanoseconds to whole clock cycles.
  function automatic int ns_to_cycles(input longint clk_hz, input longint ns);
    return int'((clk_hz * ns) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           valid,
  input  logic [7:0]     cmd_addr,
  output logic [NCH-1:0] load_mask,
  output logic [NCH-1:0] upd_mask,
  output logic [NCH-1:0] pd_mask
);

  logic [3:0]     cmd;
  logic [3:0]     addr;
  logic [NCH-1:0] sel;
  logic           addr_ok;

  assign cmd  = cmd_addr[7:4];
  assign addr = cmd_addr[3:0];

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sel[i] = (addr == ADDR_ALL) || (addr == 4'(i));
    end
    addr_ok = |sel;
  end

  always_comb begin
    load_mask = '0;
    upd_mask  = '0;
    pd_mask   = '0;
    if (valid && addr_ok) begin
      case (cmd)
        CMD_LOAD:         load_mask = sel;
        CMD_UPDATE:       upd_mask  = sel;
        CMD_LOAD_UPD_ALL: begin
          load_mask = sel;
          upd_mask  = '1;
        end
        CMD_LOAD_UPD:     begin
          load_mask = sel;
          upd_mask  = sel;
        end
        CMD_PWR_DN:       pd_mask   = sel;
        default:          ;
      endcase
    end
  end

endmodule

// File: rtl/qdac_wake_sel.sv
module qdac_wake_sel #(
  parameter int NCH       = 4,
  parameter int CNT_W     = 10,
  parameter int SHORT_CYC = 250,
  parameter int LONG_CYC  = 500
) (
  input  logic [NCH-1:0]   pd_state,
  output logic [CNT_W-1:0] wake_cycles
);

  // The long wait applies only when every channel was down before the update.
  assign wake_cycles = (&pd_state) ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
  parameter int CODE_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              upd,
  input  logic              pd_req,
  input  logic [CODE_W-1:0] data,
  input  logic [CNT_W-1:0]  wake_cycles,
  output logic [CODE_W-1:0] code,
  output logic              pd,
  output logic              settle
);

  logic [CODE_W-1:0] in_q;
  logic [CODE_W-1:0] dac_q;
  logic              pd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wake;

  assign wake = upd && pd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      dac_q <= '0;
      pd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (load) in_q <= data;
      if (upd) begin
        dac_q <= load ? data : in_q;
        pd_q  <= 1'b0;
      end else if (pd_req) begin
        pd_q  <= 1'b1;
      end
      if (wake)               cnt_q <= wake_cycles;
      else if (pd_req)        cnt_q <= '0;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign code   = dac_q;
  assign pd     = pd_q;
  assign settle = (cnt_q != '0);

endmodule

// File: rtl/qdac_cmd_core.sv
module qdac_cmd_core
  import qdac_pkg::*;
#(
  parameter int NCH           = 4,
  parameter int DATA_W        = 16,
  parameter int CODE_W        = 16,
  parameter int CLK_HZ        = 50_000_000,
  parameter int WAKE_SHORT_NS = 5000,
  parameter int WAKE_LONG_NS  = 10000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  input  logic [7:0]            wr_cmd_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [NCH-1:0]        pd_flag,
  output logic [NCH-1:0]        settle_flag
);

  localparam int SHORT_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(WAKE_SHORT_NS));
  localparam int LONG_CYC  = ns_to_cycles(longint'(CLK_HZ), longint'(WAKE_LONG_NS));
  localparam int CNT_W     = $clog2(LONG_CYC + 1);

  logic [NCH-1:0]    load_mask;
  logic [NCH-1:0]    upd_mask;
  logic [NCH-1:0]    pd_mask;
  logic [CNT_W-1:0]  wake_cycles;
  logic [CODE_W-1:0] code_in;

  // Left-justified code: keep the top CODE_W bits of the data word.
  assign code_in = wr_data[DATA_W-1 -: CODE_W];

  qdac_decode #(.NCH(NCH)) u_decode (
    .valid     (wr_valid),
    .cmd_addr  (wr_cmd_addr),
    .load_mask (load_mask),
    .upd_mask  (upd_mask),
    .pd_mask   (pd_mask)
  );

  qdac_wake_sel #(
    .NCH       (NCH),
    .CNT_W     (CNT_W),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_wake_sel (
    .pd_state    (pd_flag),
    .wake_cycles (wake_cycles)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    qdac_chan #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chan (
      .clk         (clk),
      .rst         (rst),
      .load        (load_mask[g]),
      .upd         (upd_mask[g]),
      .pd_req      (pd_mask[g]),
      .data        (code_in),
      .wake_cycles (wake_cycles),
      .code        (dac_code[g*CODE_W +: CODE_W]),
      .pd          (pd_flag[g]),
      .settle      (settle_flag[g])
    );
  end

endmodule

// File: rtl/qdac_cmd_core_chk.sv
module qdac_cmd_core_chk #(
  parameter int NCH    = 4,
  parameter int DATA_W = 16,
  parameter int CODE_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_valid,
  input logic [7:0]            wr_cmd_addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic [NCH-1:0]        pd_flag,
  input logic [NCH-1:0]        settle_flag
);

  logic [3:0] c;
  logic [3:0] a;
  logic       a_ok;
  assign c    = wr_cmd_addr[7:4];
  assign a    = wr_cmd_addr[3:0];
  assign a_ok = (a == 4'hF) || (int'(a) < NCH);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && pd_flag == '0 && settle_flag == '0));

  // R2
  load_only_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && c == 4'h0) |=> ($stable(dac_code) && $stable(pd_flag)));

  // R4
  upd_all_wakes_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && c == 4'h2 && a_ok) |=> (pd_flag == '0));

  // R6
  pwr_dn_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && c == 4'h4) |=> $stable(dac_code));

  // R7
  pwr_dn_all_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_cmd_addr == 8'h4F) |=> (&pd_flag));

  // R8
  nop_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (c > 4'h4 || !a_ok)) |=> ($stable(dac_code) && $stable(pd_flag)));

  // R11
  settle_while_up_chk: assert property (@(posedge clk) disable iff (rst)
    (settle_flag & pd_flag) == '0);

  // R9
  settle_needs_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (settle_flag & ~$past(settle_flag) & ~$past(pd_flag)) == '0);

endmodule

bind qdac_cmd_core qdac_cmd_core_chk #(
  .NCH(NCH), .DATA_W(DATA_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_cmd_addr(wr_cmd_addr),
  .wr_data(wr_data), .dac_code(dac_code), .pd_flag(pd_flag),
  .settle_flag(settle_flag)
);

// File: tb/qdac_cmd_core_bench.sv
`timescale 1ns/1ps
module qdac_cmd_core_bench;

  localparam int N       = 4;
  localparam int SHORT_N = 250;  // 5 us at 50 MHz
  localparam int LONG_N  = 500;  // 10 us at 50 MHz

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_cmd_addr = 8'h00;
  logic [15:0] wr_data = 16'h0000;
  logic [63:0] dac_code;
  logic [3:0]  pd_flag;
  logic [3:0]  settle_flag;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  qdac_cmd_core u_qdac_cmd_core (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_cmd_addr(wr_cmd_addr),
    .wr_data(wr_data), .dac_code(dac_code), .pd_flag(pd_flag),
    .settle_flag(settle_flag)
  );

  // Behavioural reference model
  int m_in[N];
  int m_dac[N];
  int m_pd[N];
  int m_cnt[N];

  always @(posedge clk) begin
    int cmd, adr, allpd;
    bit ld, up, dn, ok, sel;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_in[i] = 0; m_dac[i] = 0; m_pd[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      cmd = int'(wr_cmd_addr[7:4]);
      adr = int'(wr_cmd_addr[3:0]);
      ok  = (adr == 15) || (adr < N);
      allpd = 1;
      for (int i = 0; i < N; i++) if (m_pd[i] == 0) allpd = 0;
      for (int i = 0; i < N; i++) begin
        sel = wr_valid && ok && (adr == 15 || adr == i);
        ld = sel && (cmd == 0 || cmd == 2 || cmd == 3);
        up = (sel && (cmd == 1 || cmd == 3)) || (wr_valid && ok && cmd == 2);
        dn = sel && cmd == 4;
        if (up && m_pd[i] == 1)  m_cnt[i] = allpd ? LONG_N : SHORT_N;
        else if (dn)             m_cnt[i] = 0;
        else if (m_cnt[i] > 0)   m_cnt[i] = m_cnt[i] - 1;
        if (up) begin
          m_dac[i] = ld ? int'(wr_data) : m_in[i];
          m_pd[i]  = 0;
        end else if (dn) begin
          m_pd[i]  = 1;
        end
        if (ld) m_in[i] = int'(wr_data);
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    logic [63:0] ec;
    logic [3:0]  ep, es;
    if (!done) begin
      for (int i = 0; i < N; i++) begin
        ec[i*16 +: 16] = 16'(m_dac[i]);
        ep[i] = (m_pd[i] != 0);
        es[i] = (m_cnt[i] != 0);
      end
      tests++;
      if (dac_code !== ec) begin
        fails++;
        $display("FAIL R5 model codes: actual %h expected %h", dac_code, ec);
      end
      if (pd_flag !== ep) begin
        fails++;
        $display("FAIL R6 model power-down: actual %b expected %b", pd_flag, ep);
      end
      if (settle_flag !== es) begin
        fails++;
        $display("FAIL R9 model settle: actual %b expected %b", settle_flag, es);
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] cmd, input logic [3:0] adr, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_cmd_addr = {cmd, adr}; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_cmd_addr = 8'h00; wr_data = 16'h0000;
  endtask

  task automatic settle_len(input int ch, output int n);
    n = 0;
    while (settle_flag[ch] && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] code_of(input int ch);
    return dac_code[ch*16 +: 16];
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 codes", dac_code, 0);
    check("R1 pd", pd_flag, 0);
    check("R1 settle", settle_flag, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", dac_code, 0);

    // R2 load only: output unchanged
    send(4'h0, 4'h0, 16'h1234);
    check("R2 load leaves code A", code_of(0), 16'h0000);
    // R3 update copies input register
    send(4'h1, 4'h0, 16'hFFFF);
    check("R3 update A", code_of(0), 16'h1234);
    // R5 load and update channel B
    send(4'h3, 4'h1, 16'hBEEF);
    check("R5 B code", code_of(1), 16'hBEEF);
    check("R5 A untouched", code_of(0), 16'h1234);
    // R7 all-address load, then update C alone
    send(4'h0, 4'hF, 16'h5555);
    send(4'h1, 4'h2, 16'h0000);
    check("R7 C from all-load", code_of(2), 16'h5555);
    check("R7 B still old", code_of(1), 16'hBEEF);
    // R6 power down D
    send(4'h4, 4'h3, 16'hAAAA);
    check("R6 pd D", pd_flag, 4'b1000);
    check("R6 codes kept", dac_code, {16'h0000, 16'h5555, 16'hBEEF, 16'h1234});
    // R9 wake D with others up: short settle
    send(4'h1, 4'h3, 16'h0000);
    check("R9 D pd cleared", pd_flag, 4'b0000);
    check("R9 D code", code_of(3), 16'h5555);
    settle_len(3, n);
    check("R9 short settle length", n, SHORT_N);

    // R8 reserved command, reserved address, no-op
    send(4'h5, 4'h0, 16'h0BAD);
    send(4'h3, 4'h4, 16'h0BAD);
    send(4'h0, 4'h7, 16'h0BAD);
    send(4'hF, 4'hF, 16'h0BAD);
    check("R8 codes unchanged", dac_code, {16'h5555, 16'h5555, 16'hBEEF, 16'h1234});
    send(4'h1, 4'hF, 16'h0000);
    check("R8 input regs unchanged", dac_code, {16'h5555, 16'h5555, 16'h5555, 16'h5555});

    // R11 power down during settle clears it
    send(4'h4, 4'h0, 16'h0000);
    send(4'h1, 4'h0, 16'h0000);
    check("R11 A settling", settle_flag, 4'b0001);
    send(4'h4, 4'h0, 16'h0000);
    check("R11 settle cleared", settle_flag, 4'b0000);

    // R10 all down, then load-and-update-all wakes everyone with long settle
    send(4'h4, 4'hF, 16'h0000);
    check("R10 all down", pd_flag, 4'b1111);
    send(4'h2, 4'h0, 16'h0F0F);
    check("R4 all up", pd_flag, 4'b0000);
    check("R4 codes", dac_code, {16'h5555, 16'h5555, 16'h5555, 16'h0F0F});
    check("R10 all settling", settle_flag, 4'b1111);
    settle_len(2, n);
    check("R10 long settle length", n, LONG_N);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule